// File: doc/BRIEF.md
# RAM-Backed VGA Frame Scanner

This block scans a raster for a VGA monitor from a single pixel clock. Two counters track the position within the line and within the frame. From them the block derives active-low horizontal and vertical sync and a blanking flag. While the beam is in the visible area, the block reads the picture from an external byte-wide asynchronous static RAM.

Every RAM byte holds four 2-bit pixels. The block presents a new byte address every fourth clock and sends the pixel pairs out most-significant first. Each 2-bit pixel passes through a fixed four-entry palette that produces six RGB drive bits. The read path has two pipeline stages:

- A fetch stage latches the RAM byte, the pixel phase, the blank flag and both syncs together.
- A colour stage turns the latched pixel and blank into the RGB output and registers the syncs beside it.

As a result, colour, blank and sync always leave the block in the same cycle. The RAM is only ever read, so its write strobe stays inactive.

Top module: `vga_frame_scanner`

## Requirements
- R1: `vga_hsync_n` is low exactly for the pixels whose line position is greater than 291 and less than 337 (positions 292 to 336), and high for every other position.
- R2: A line lasts H_TOTAL clocks (positions 0 to H_TOTAL-1). The line counter advances when the position wraps from H_TOTAL-1 to 0. A frame lasts V_TOTAL lines, and the line counter returns to 0 after line V_TOTAL-1.
- R3: `vga_vsync_n` is low exactly for lines VS_FIRST to VS_LAST inclusive, and high for all other lines.
- R4: `vga_blank` is high for a pixel when its line position is 256 or more, or when its line number is V_VISIBLE or more. Otherwise it is low.
- R5: Whenever `vga_blank` is high, `vga_rgb` is 0, whatever the RAM returns.
- R6: `ram_addr` is {line number in the upper ADDR_W-6 bits, line position bits 7:2 in the lower 6 bits}. It follows the counters without delay, so it changes only when the position crosses a multiple of four or wraps.
- R7: Position bits 1:0 select the pixel within a byte. Phase 0 takes data bits 7:6, phase 1 takes bits 5:4, phase 2 takes bits 3:2 and phase 3 takes bits 1:0.
- R8: The palette maps pixel 0 to RGB 6'b00_00_00, pixel 1 to 6'b00_00_11, pixel 2 to 6'b00_11_00 and pixel 3 to 6'b11_11_11. The layout of `vga_rgb` is {red[1:0], green[1:0], blue[1:0]}.
- R9: `vga_rgb`, `vga_blank`, `vga_hsync_n` and `vga_vsync_n` all describe the pixel whose position the counters held two clocks earlier.
- R10: `ram_we_n` is always high. `ram_ce_n` and `ram_oe_n` are high while reset is applied and low from the first clock after reset is released.
- R11: A clock edge with `rst_n` low clears both counters, which makes `ram_addr` 0. The same edge sets `vga_rgb` to 0 and drives `vga_blank`, `vga_hsync_n` and `vga_vsync_n` high. This state holds until reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ram_addr | output | ADDR_W | Byte address to the static RAM |
| ram_data | input | 8 | Byte read back from the static RAM |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low, held inactive |
| ram_oe_n | output | 1 | RAM output enable, active low |
| vga_rgb | output | 6 | Colour drive {red, green, blue}, two bits each |
| vga_hsync_n | output | 1 | Horizontal sync, active low |
| vga_vsync_n | output | 1 | Vertical sync, active low |
| vga_blank | output | 1 | High while the pixel lies outside the visible area |

## Verification
The assertions assume that `ram_data` is valid within the same clock as the address that selects it. In other words, they assume the RAM behaves as a zero-latency combinational read. They also assume that reset is held low for at least one clock edge before counting starts.

The bench meets these assumptions with an array model that answers the address combinationally. It changes `rst_n` only on falling edges and holds it low for several cycles each time. The bench also resets the block partway through a line and frame, then restarts the scan from there.

// File: rtl/vga_scan_pkg.sv
// Package vga_scan_pkg
// Holds the constants and types shared by the frame scanner modules.
// Assumes a byte-wide frame store holding 2-bit pixels.
package vga_scan_pkg;

    localparam int BYTE_W       = 8;
    localparam int PIX_W        = 2;
    localparam int PIX_PER_BYTE = BYTE_W / PIX_W;
    localparam int PHASE_W      = $clog2(PIX_PER_BYTE);
    localparam int RGB_W        = 6;

    // Contents of the fetch-stage register
    typedef struct packed {
        logic [BYTE_W-1:0]  data;
        logic [PHASE_W-1:0] phase;
        logic               blank;
        logic               hs_n;
        logic               vs_n;
    } fetch_stage_t;

    // Fixed palette: pixel code to {r[1:0], g[1:0], b[1:0]}
    function automatic logic [RGB_W-1:0] palette_lookup(input logic [PIX_W-1:0] code);
        logic [RGB_W-1:0] colour;
        case (code)
            2'd0:    colour = 6'b00_00_00;
            2'd1:    colour = 6'b00_00_11;
            2'd2:    colour = 6'b00_11_00;
            default: colour = 6'b11_11_11;
        endcase
        return colour;
    endfunction

endpackage

// File: rtl/vga_raster_timing.sv
// Module vga_raster_timing
// Counts the pixel position within a line and the line number within a frame.
// From these counts it derives raw (not yet pipelined) blank and active-low sync.
// Assumes H_TOTAL > HS_BEFORE and V_TOTAL > VS_LAST.
module vga_raster_timing #(
    parameter int H_TOTAL   = 381,
    parameter int H_VISIBLE = 256,
    parameter int HS_AFTER  = 291,
    parameter int HS_BEFORE = 337,
    parameter int V_TOTAL   = 525,
    parameter int V_VISIBLE = 480,
    parameter int VS_FIRST  = 490,
    parameter int VS_LAST   = 491,
    localparam int HCNT_W   = $clog2(H_TOTAL),
    localparam int VCNT_W   = $clog2(V_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [HCNT_W-1:0] hcnt,
    output logic [VCNT_W-1:0] vcnt,
    output logic              raw_blank,
    output logic              raw_hs_n,
    output logic              raw_vs_n
);

    localparam logic [HCNT_W-1:0] H_LAST  = HCNT_W'(H_TOTAL - 1);
    localparam logic [HCNT_W-1:0] H_VIS_C = HCNT_W'(H_VISIBLE);
    localparam logic [HCNT_W-1:0] HS_LO   = HCNT_W'(HS_AFTER);
    localparam logic [HCNT_W-1:0] HS_HI   = HCNT_W'(HS_BEFORE);
    localparam logic [VCNT_W-1:0] V_LAST  = VCNT_W'(V_TOTAL - 1);
    localparam logic [VCNT_W-1:0] V_VIS_C = VCNT_W'(V_VISIBLE);
    localparam logic [VCNT_W-1:0] VS_LO   = VCNT_W'(VS_FIRST);
    localparam logic [VCNT_W-1:0] VS_HI   = VCNT_W'(VS_LAST);

    logic line_end;

    // Flags the last pixel of a line
    always_comb line_end = (hcnt == H_LAST);

    // Advances the pixel position and wraps it at the end of the line
    always_ff @(posedge clk) begin
        if (!rst_n)        hcnt <= '0;
        else if (line_end) hcnt <= '0;
        else               hcnt <= hcnt + 1'b1;
    end

    // Advances the line number at each line wrap and wraps it at the end of the frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt <= '0;
        end else if (line_end) begin
            if (vcnt == V_LAST) vcnt <= '0;
            else                vcnt <= vcnt + 1'b1;
        end
    end

    // Decodes raw blank and syncs from the counters
    always_comb begin
        raw_blank = (hcnt >= H_VIS_C) || (vcnt >= V_VIS_C);
        raw_hs_n  = !((hcnt > HS_LO) && (hcnt < HS_HI));
        raw_vs_n  = !((vcnt >= VS_LO) && (vcnt <= VS_HI));
    end

    AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= H_LAST);                                                   // R2
    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && vcnt != V_LAST) |=> (hcnt == '0 && vcnt == $past(vcnt) + 1'b1)); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && vcnt == V_LAST) |=> (hcnt == '0 && vcnt == '0));      // R2
    AST_MID_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_end) |=> $stable(vcnt));                                    // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        (!rst_n) |=> (hcnt == '0 && vcnt == '0));                          // R11

endmodule

// File: rtl/vga_byte_fetch.sv
// Module vga_byte_fetch
// Pipeline stage 1. It forms the RAM byte address from the raster counters.
// At the end of the stage it latches the returned byte, the pixel phase, the blank
// flag and both syncs into one register.
// Assumes the RAM returns data within the same clock as the address.
module vga_byte_fetch
    import vga_scan_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int H_TOTAL   = 381,
    parameter int H_VISIBLE = 256,
    parameter int V_TOTAL   = 525,
    localparam int HCNT_W   = $clog2(H_TOTAL),
    localparam int VCNT_W   = $clog2(V_TOTAL),
    localparam int COL_W    = $clog2(H_VISIBLE / PIX_PER_BYTE),
    localparam int ROW_W    = ADDR_W - COL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HCNT_W-1:0]  hcnt,
    input  logic [VCNT_W-1:0]  vcnt,
    input  logic               raw_blank,
    input  logic               raw_hs_n,
    input  logic               raw_vs_n,
    input  logic [BYTE_W-1:0]  ram_data,
    output logic [ADDR_W-1:0]  ram_addr,
    output fetch_stage_t       s1_q
);

    localparam logic [HCNT_W-1:0] H_LAST = HCNT_W'(H_TOTAL - 1);

    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;

    // Maps line number to the upper address bits and byte column to the lower bits
    always_comb begin
        row      = ROW_W'(vcnt);
        col      = hcnt[COL_W+PHASE_W-1:PHASE_W];
        ram_addr = {row, col};
    end

    // Latches byte, phase, blank and syncs together at the end of stage 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q.data  <= '0;
            s1_q.phase <= '0;
            s1_q.blank <= 1'b1;
            s1_q.hs_n  <= 1'b1;
            s1_q.vs_n  <= 1'b1;
        end else begin
            s1_q.data  <= ram_data;
            s1_q.phase <= hcnt[PHASE_W-1:0];
            s1_q.blank <= raw_blank;
            s1_q.hs_n  <= raw_hs_n;
            s1_q.vs_n  <= raw_vs_n;
        end
    end

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt[PHASE_W-1:0] != '1 && hcnt != H_LAST) |=> $stable(ram_addr)); // R6
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.phase != '1 && !s1_q.blank) |=> (s1_q.phase == $past(s1_q.phase) + 1'b1 || s1_q.blank)); // R7

endmodule

// File: rtl/vga_colour_stage.sv
// Module vga_colour_stage
// Pipeline stage 2. It picks the pixel pair named by the latched phase, most
// significant pair first, and maps it through the palette. It forces black while
// blanked and registers colour, blank and syncs together.
// Assumes its input comes from the stage-1 register.
module vga_colour_stage
    import vga_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fetch_stage_t     s1_q,
    output logic [RGB_W-1:0] rgb_q,
    output logic             blank_q,
    output logic             hs_n_q,
    output logic             vs_n_q
);

    logic [PIX_W-1:0] pix [PIX_PER_BYTE];
    logic [PIX_W-1:0] pix_sel;
    logic [RGB_W-1:0] colour;

    // Slices the byte into pixel pairs, pair 0 at the top
    for (genvar g = 0; g < PIX_PER_BYTE; g++) begin : g_slice
        assign pix[g] = s1_q.data[BYTE_W-1-g*PIX_W -: PIX_W];
    end

    // Selects the current pair and looks up its colour
    always_comb begin
        pix_sel = pix[s1_q.phase];
        colour  = palette_lookup(pix_sel);
    end

    // Registers colour with blank and syncs so all leave aligned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_q   <= '0;
            blank_q <= 1'b1;
            hs_n_q  <= 1'b1;
            vs_n_q  <= 1'b1;
        end else begin
            rgb_q   <= s1_q.blank ? '0 : colour;
            blank_q <= s1_q.blank;
            hs_n_q  <= s1_q.hs_n;
            vs_n_q  <= s1_q.vs_n;
        end
    end

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q.blank |=> (rgb_q == '0 && blank_q));                          // R5
    AST_SYNC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hs_n_q == $past(s1_q.hs_n) && vs_n_q == $past(s1_q.vs_n))); // R9

endmodule

// File: rtl/vga_frame_scanner.sv
// Module vga_frame_scanner
// Top level of the RAM-backed VGA frame scanner. It chains raster timing, byte
// fetch and colour stages and drives the RAM strobes for read-only use.
// Assumes an asynchronous RAM that answers within one pixel clock.
module vga_frame_scanner
    import vga_scan_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int H_TOTAL   = 381,
    parameter int H_VISIBLE = 256,
    parameter int HS_AFTER  = 291,
    parameter int HS_BEFORE = 337,
    parameter int V_TOTAL   = 525,
    parameter int V_VISIBLE = 480,
    parameter int VS_FIRST  = 490,
    parameter int VS_LAST   = 491
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [7:0]        ram_data,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [5:0]        vga_rgb,
    output logic              vga_hsync_n,
    output logic              vga_vsync_n,
    output logic              vga_blank
);

    localparam int HCNT_W = $clog2(H_TOTAL);
    localparam int VCNT_W = $clog2(V_TOTAL);

    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;
    logic              raw_blank;
    logic              raw_hs_n;
    logic              raw_vs_n;
    fetch_stage_t      s1_q;
    logic              rd_en_q;
    logic [1:0]        since_rst;

    vga_raster_timing #(
        .H_TOTAL   (H_TOTAL),
        .H_VISIBLE (H_VISIBLE),
        .HS_AFTER  (HS_AFTER),
        .HS_BEFORE (HS_BEFORE),
        .V_TOTAL   (V_TOTAL),
        .V_VISIBLE (V_VISIBLE),
        .VS_FIRST  (VS_FIRST),
        .VS_LAST   (VS_LAST)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .hcnt      (hcnt),
        .vcnt      (vcnt),
        .raw_blank (raw_blank),
        .raw_hs_n  (raw_hs_n),
        .raw_vs_n  (raw_vs_n)
    );

    vga_byte_fetch #(
        .ADDR_W    (ADDR_W),
        .H_TOTAL   (H_TOTAL),
        .H_VISIBLE (H_VISIBLE),
        .V_TOTAL   (V_TOTAL)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hcnt      (hcnt),
        .vcnt      (vcnt),
        .raw_blank (raw_blank),
        .raw_hs_n  (raw_hs_n),
        .raw_vs_n  (raw_vs_n),
        .ram_data  (ram_data),
        .ram_addr  (ram_addr),
        .s1_q      (s1_q)
    );

    vga_colour_stage u_colour (
        .clk     (clk),
        .rst_n   (rst_n),
        .s1_q    (s1_q),
        .rgb_q   (vga_rgb),
        .blank_q (vga_blank),
        .hs_n_q  (vga_hsync_n),
        .vs_n_q  (vga_vsync_n)
    );

    // Enables RAM reads from the first clock after reset
    always_ff @(posedge clk) begin
        if (!rst_n) rd_en_q <= 1'b0;
        else        rd_en_q <= 1'b1;
    end

    // Drives the RAM strobes; writes are never issued
    always_comb begin
        ram_ce_n = !rd_en_q;
        ram_oe_n = !rd_en_q;
        ram_we_n = 1'b1;
    end

    // Counts clocks since reset (saturating) to guard the latency check
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != '1) since_rst <= since_rst + 1'b1;
    end

    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (vga_hsync_n == $past(raw_hs_n, 2)
                                 && vga_vsync_n == $past(raw_vs_n, 2)
                                 && vga_blank == $past(raw_blank, 2)));     // R9
    AST_STROBES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) |-> (!ram_ce_n && !ram_oe_n && ram_we_n));      // R10

endmodule

// File: tb/vga_frame_scanner_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task pushes the expected outputs for each raster
// position, and a monitor pops and compares them two clocks later.
module vga_frame_scanner_tb;

    localparam int ADDR_W  = 15;
    localparam int H_TOT   = 381;
    localparam int H_VIS   = 256;
    localparam int V_TOT   = 8;
    localparam int V_VIS   = 4;
    localparam int VS_F    = 5;
    localparam int VS_L    = 6;
    localparam int MEM_N   = 512;

    typedef struct packed {
        logic [5:0] rgb;
        logic       hs_n;
        logic       vs_n;
        logic       blank;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_data;
    logic              ram_ce_n, ram_we_n, ram_oe_n;
    logic [5:0]        vga_rgb;
    logic              vga_hsync_n, vga_vsync_n, vga_blank;

    logic [7:0] mem [MEM_N];
    exp_t       q [$];
    bit         run = 1'b0;
    int         mh, mv;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    assign ram_data = mem[ram_addr[8:0]];

    vga_frame_scanner #(
        .ADDR_W(ADDR_W), .H_TOTAL(H_TOT), .H_VISIBLE(H_VIS),
        .HS_AFTER(291), .HS_BEFORE(337),
        .V_TOTAL(V_TOT), .V_VISIBLE(V_VIS), .VS_FIRST(VS_F), .VS_LAST(VS_L)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ram_addr(ram_addr), .ram_data(ram_data),
        .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .vga_rgb(vga_rgb), .vga_hsync_n(vga_hsync_n),
        .vga_vsync_n(vga_vsync_n), .vga_blank(vga_blank)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (h=%0d v=%0d)", tag, act, exp, mh, mv);
        end
    endtask

    // R8 palette written out from the requirement
    function automatic logic [5:0] colour_of(input logic [1:0] c);
        case (c)
            2'd0: return 6'b000000;
            2'd1: return 6'b000011;
            2'd2: return 6'b001100;
            default: return 6'b111111;
        endcase
    endfunction

    // Driver: checks the address of the current position, queues its expected outputs, advances
    task automatic push_expected();
        exp_t e;
        logic [7:0] b;
        logic [1:0] px;
        int addr;
        addr = (mv << 6) | ((mh >> 2) & 63);                         // R6 layout
        check("R6 ram_addr", 32'(ram_addr), 32'(addr));
        b  = mem[addr % MEM_N];
        px = 2'((b >> (6 - 2 * (mh % 4))) & 3);                      // R7 MSB pair first
        e.blank = (mh >= 256) || (mv >= V_VIS);                      // R4
        e.hs_n  = !(mh > 291 && mh < 337);                           // R1
        e.vs_n  = !(mv >= VS_F && mv <= VS_L);                       // R3
        e.rgb   = e.blank ? 6'd0 : colour_of(px);                    // R5 R8
        q.push_back(e);
        mh++;                                                        // R2 line and frame wrap
        if (mh == H_TOT) begin
            mh = 0;
            mv++;
            if (mv == V_TOT) mv = 0;
        end
    endtask

    // Monitor: compares outputs against the entry two clocks old (R9 latency)
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (run && q.size() >= 3) begin
            e = q.pop_front();
            check("R1 hsync",  32'(vga_hsync_n), 32'(e.hs_n));
            check("R3 vsync",  32'(vga_vsync_n), 32'(e.vs_n));
            check("R4 blank",  32'(vga_blank),   32'(e.blank));
            check(e.blank ? "R5 rgb dark" : "R8 rgb colour", 32'(vga_rgb), 32'(e.rgb));
            check("R10 strobes", 32'({ram_ce_n, ram_oe_n, ram_we_n}), 32'(3'b001));
        end
    end

    task automatic run_cycles(input int n);
        repeat (n) begin
            @(negedge clk);
            push_expected();
        end
    endtask

    task automatic start_scan();
        @(negedge clk);
        rst_n = 1'b1;
        run   = 1'b1;
        mh    = 0;
        mv    = 0;
        push_expected();
    endtask

    task automatic check_reset_state(input string when);
        check({"R11 rgb ", when},   32'(vga_rgb), 32'd0);
        check({"R11 blank ", when}, 32'(vga_blank), 32'd1);
        check({"R11 syncs ", when}, 32'({vga_hsync_n, vga_vsync_n}), 32'd3);
        check({"R11 addr ", when},  32'(ram_addr), 32'd0);
        check({"R10 strobes ", when}, 32'({ram_ce_n, ram_oe_n, ram_we_n}), 32'd7);
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 29 + 7) ^ (i >> 3));
        mem[0] = 8'b00_01_10_11;   // every code in one byte, R7 order
        mem[1] = 8'b11_10_01_00;
        repeat (4) @(negedge clk);
        check_reset_state("initial");
        start_scan();
        run_cycles(3 * V_TOT * H_TOT + 2 * H_TOT + 150);
        // mid-line, mid-frame reset (R11)
        @(negedge clk);
        rst_n = 1'b0;
        run   = 1'b0;
        q.delete();
        repeat (3) @(negedge clk);
        #1;
        check_reset_state("mid-frame");
        start_scan();
        run_cycles(V_TOT * H_TOT + 20);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule